// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block merges one dedicated active-low interrupt pin and a parameterized group of general-purpose port pins into a single maskable interrupt request for a small 8-bit CPU. A port pin counts as a source only while its pull-up enable bit is set. Once it counts, it behaves exactly like the dedicated pin. Every pin passes through a two-stage synchronizer. The synchronized levels are then ANDed into one combined active-low level. A high-to-low transition of that combined level sets a pending latch.

A sensitivity bit selects the trigger mode. In edge-only mode, only the pending latch can raise the request. In edge-and-level mode, the request is also raised for as long as the combined level stays low. The CPU's global mask bit blocks the request without disturbing the pending latch. A one-cycle acknowledge from the CPU's interrupt entry sequence clears the latch, so one new pulse that arrives during servicing is held until the mask is lifted. The registered combined level is also brought out so that the CPU can run its branch-on-pin-state instructions.

Top module: `xirq_conditioner`

## Requirements
- R1: Synchronous reset drives `irq_req` to 0 and `pin_level` to 1.
- R2: When the dedicated pin is driven low, `irq_req` rises on the 4th rising clock edge after the change. In edge-only mode it then stays high after the pin returns high, until an acknowledge arrives.
- R3: While `gmask` is 1, `irq_req` is 0 from the next edge on, and the pending state is kept. After `gmask` is cleared, a pending request appears on the next edge.
- R4: A port pin whose `port_pu_en` bit is 0 has no effect on `irq_req` or `pin_level`. A port pin whose bit is 1 raises the request just as the dedicated pin does.
- R5: `edge_only` = 1 selects edge-only mode. In this mode an acknowledge clears the request (low two edges after the acknowledge is driven), even while the pin stays low.
- R6: `edge_only` = 0 selects edge-and-level mode. In this mode `irq_req` stays 1 while the combined level is low, even after an acknowledge, and drops once the level is high and nothing is pending.
- R7: `pin_level` is the AND of the dedicated pin and every enabled port pin. It shows a pin change on the 3rd rising edge after that change.
- R8: A falling edge of the combined level in the same cycle as an acknowledge leaves the request pending.
- R9: A single pulse that arrives after an acknowledge while `gmask` is 1 is held, and it is requested once `gmask` is cleared.
- R10: A second source going low while the combined level is already low creates no new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_pin | input | 1 | Dedicated active-low interrupt pin |
| port_pins | input | NPORT | Port pins usable as extra active-low sources |
| port_pu_en | input | NPORT | Pull-up enables; 1 makes the matching port pin a source |
| edge_only | input | 1 | 1 = edge-only, 0 = edge-and-level sensitivity |
| gmask | input | 1 | CPU global interrupt mask; 1 blocks the request |
| irq_ack | input | 1 | One-cycle acknowledge from interrupt entry |
| irq_req | output | 1 | Registered interrupt request to the CPU |
| pin_level | output | 1 | Registered combined pin level for branch-on-pin tests |

## Verification
The bench goes after an edge that lands in the same cycle as an acknowledge. A design in which the acknowledge wins would lose that interrupt, and `irq_req` would drop. It checks that a low pin held past an acknowledge re-requests only in level mode. A design that mixes up the modes would either storm the CPU or miss a held-low device. It checks that a second wired source going low under an already-low level produces no fresh edge, and that a port pin without its pull-up enable is ignored. Finally, it checks that a pulse arriving under the mask is held and released when the mask clears, rather than being dropped or leaking through.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic {
    SENS_LEVEL_EDGE = 1'b0,
    SENS_EDGE_ONLY  = 1'b1
  } sens_e;

  localparam logic PIN_IDLE = 1'b1;
  localparam int   SYNC_STAGES = 2;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  import xirq_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= {SYNC_STAGES{PIN_IDLE}};
      else     chain_q <= {chain_q[SYNC_STAGES-2:0], raw_in[i]};
    end
    assign sync_out[i] = chain_q[SYNC_STAGES-1];
  end

  // R1: synchronizer outputs idle high after reset
  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> (sync_out == {WIDTH{PIN_IDLE}}));
endmodule

// File: rtl/xirq_combine.sv
module xirq_combine #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ded_lvl,
  input  logic [NPORT-1:0] port_lvl,
  input  logic [NPORT-1:0] pu_en,
  output logic             lvl_q,
  output logic             fall
);
  import xirq_pkg::*;

  logic [NPORT-1:0] eff;
  logic             comb;

  for (genvar i = 0; i < NPORT; i++) begin : g_src
    assign eff[i] = port_lvl[i] | ~pu_en[i];
  end

  always_comb begin
    comb = ded_lvl & (&eff);
    fall = lvl_q & ~comb;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= PIN_IDLE;
    else     lvl_q <= comb;
  end

  // R10: a falling edge is only seen while the previous level was high
  p_fall_from_high_r10: assert property (@(posedge clk) disable iff (rst)
    fall |=> !lvl_q);
endmodule

// File: rtl/xirq_latch.sv
module xirq_latch (
  input  logic           clk,
  input  logic           rst,
  input  logic           fall,
  input  logic           level_low,
  input  logic           ack,
  input  logic           gmask,
  input  xirq_pkg::sens_e mode,
  output logic           req
);
  import xirq_pkg::*;

  logic pend_q;
  logic raw;

  always_ff @(posedge clk) begin
    if (rst)       pend_q <= 1'b0;
    else if (fall) pend_q <= 1'b1;
    else if (ack)  pend_q <= 1'b0;
  end

  always_comb raw = pend_q | ((mode == SENS_LEVEL_EDGE) & level_low);

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= raw & ~gmask;
  end

  p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
    fall |=> pend_q);
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && !fall) |=> !pend_q);
  p_edge_beats_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && fall) |=> pend_q);
  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    gmask |=> !req);
  p_level_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == SENS_LEVEL_EDGE && level_low && !gmask) |=> req);
  p_pend_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!fall && !ack) |=> $stable(pend_q));
endmodule

// File: rtl/xirq_conditioner.sv
module xirq_conditioner #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_n_pin,
  input  logic [NPORT-1:0] port_pins,
  input  logic [NPORT-1:0] port_pu_en,
  input  logic             edge_only,
  input  logic             gmask,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic             pin_level
);
  import xirq_pkg::*;

  localparam int NPIN = NPORT + 1;

  logic [NPIN-1:0] sync_lvl;
  logic            lvl_q;
  logic            fall;
  sens_e           mode;

  assign mode = sens_e'(edge_only);

  xirq_sync #(.WIDTH(NPIN)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .raw_in   ({port_pins, irq_n_pin}),
    .sync_out (sync_lvl)
  );

  xirq_combine #(.NPORT(NPORT)) u_comb (
    .clk      (clk),
    .rst      (rst),
    .ded_lvl  (sync_lvl[0]),
    .port_lvl (sync_lvl[NPIN-1:1]),
    .pu_en    (port_pu_en),
    .lvl_q    (lvl_q),
    .fall     (fall)
  );

  xirq_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .fall      (fall),
    .level_low (~lvl_q),
    .ack       (irq_ack),
    .gmask     (gmask),
    .mode      (mode),
    .req       (irq_req)
  );

  assign pin_level = lvl_q;

  // R7: a high combined level follows only when every enabled source is high
  p_level_high_r7: assert property (@(posedge clk) disable iff (rst)
    (sync_lvl[0] && ((sync_lvl[NPIN-1:1] | ~port_pu_en) == {NPORT{1'b1}}))
      |=> pin_level);
endmodule

// File: tb/xirq_conditioner_tb.sv
`timescale 1ns/1ps
module xirq_conditioner_tb;
  localparam int NPORT = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             irq_n_pin = 1'b1;
  logic [NPORT-1:0] port_pins = '1;
  logic [NPORT-1:0] port_pu_en = '0;
  logic             edge_only = 1'b1;
  logic             gmask = 1'b0;
  logic             irq_ack = 1'b0;
  logic             irq_req;
  logic             pin_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xirq_conditioner #(.NPORT(NPORT)) u_dut (
    .clk(clk), .rst(rst), .irq_n_pin(irq_n_pin), .port_pins(port_pins),
    .port_pu_en(port_pu_en), .edge_only(edge_only), .gmask(gmask),
    .irq_ack(irq_ack), .irq_req(irq_req), .pin_level(pin_level)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    check("R1", irq_req, 1'b0, "req after reset");
    check("R1", pin_level, 1'b1, "level after reset");
  endtask

  task automatic t_dedicated_edge();
    edge_only = 1'b1;
    irq_n_pin = 1'b0;
    step(3);
    check("R2", irq_req, 1'b0, "req before 4th edge");
    check("R7", pin_level, 1'b0, "level on 3rd edge");
    step(1);
    check("R2", irq_req, 1'b1, "req on 4th edge");
    irq_n_pin = 1'b1;
    step(6);
    check("R2", irq_req, 1'b1, "req held after pin high");
    ack_pulse();
    check("R5", irq_req, 1'b0, "req cleared by ack");
  endtask

  task automatic t_edge_only_hold();
    edge_only = 1'b1;
    irq_n_pin = 1'b0;
    step(4);
    check("R5", irq_req, 1'b1, "req from edge");
    ack_pulse();
    check("R5", irq_req, 1'b0, "req dropped, pin still low");
    step(3);
    check("R5", irq_req, 1'b0, "no re-request while low");
    irq_n_pin = 1'b1;
    step(4);
  endtask

  task automatic t_level();
    edge_only = 1'b0;
    irq_n_pin = 1'b0;
    step(4);
    check("R6", irq_req, 1'b1, "req in level mode");
    ack_pulse();
    step(2);
    check("R6", irq_req, 1'b1, "req held by low level after ack");
    irq_n_pin = 1'b1;
    step(4);
    check("R6", irq_req, 1'b0, "req dropped after level high");
    edge_only = 1'b1;
  endtask

  task automatic t_mask();
    edge_only = 1'b1;
    gmask = 1'b1;
    irq_n_pin = 1'b0;
    step(3);
    irq_n_pin = 1'b1;
    step(6);
    check("R3", irq_req, 1'b0, "req blocked by mask");
    gmask = 1'b0;
    step(1);
    check("R3", irq_req, 1'b1, "pending released after unmask");
    ack_pulse();
  endtask

  task automatic t_port();
    edge_only = 1'b1;
    port_pins[0] = 1'b0;
    step(6);
    check("R4", irq_req, 1'b0, "disabled port pin ignored (req)");
    check("R4", pin_level, 1'b1, "disabled port pin ignored (level)");
    port_pins[0] = 1'b1;
    port_pu_en[1] = 1'b1;
    step(2);
    port_pins[1] = 1'b0;
    step(3);
    check("R7", pin_level, 1'b0, "enabled port pin lowers level");
    step(1);
    check("R4", irq_req, 1'b1, "enabled port pin requests");
    port_pins[1] = 1'b1;
    step(3);
    ack_pulse();
    check("R4", irq_req, 1'b0, "port request acknowledged");
    port_pu_en = '0;
    step(2);
  endtask

  task automatic t_ack_edge_same();
    edge_only = 1'b1;
    irq_n_pin = 1'b0;
    step(3);
    irq_n_pin = 1'b1;
    step(5);
    check("R8", irq_req, 1'b1, "prior pending set");
    irq_n_pin = 1'b0;
    step(2);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    step(2);
    check("R8", irq_req, 1'b1, "edge with ack kept pending");
    irq_n_pin = 1'b1;
    step(4);
    ack_pulse();
    check("R8", irq_req, 1'b0, "cleared afterwards");
  endtask

  task automatic t_service_pulse();
    edge_only = 1'b1;
    irq_n_pin = 1'b0;
    step(3);
    irq_n_pin = 1'b1;
    step(3);
    irq_ack = 1'b1;
    gmask = 1'b1;
    step(1);
    irq_ack = 1'b0;
    step(1);
    irq_n_pin = 1'b0;
    step(3);
    irq_n_pin = 1'b1;
    step(5);
    check("R9", irq_req, 1'b0, "new pulse held under mask");
    gmask = 1'b0;
    step(1);
    check("R9", irq_req, 1'b1, "held pulse serviced on unmask");
    ack_pulse();
  endtask

  task automatic t_wired_no_double();
    edge_only = 1'b1;
    port_pu_en[0] = 1'b1;
    step(2);
    irq_n_pin = 1'b0;
    step(4);
    check("R10", irq_req, 1'b1, "first source requests");
    ack_pulse();
    port_pins[0] = 1'b0;
    step(6);
    check("R10", irq_req, 1'b0, "second low source adds no edge");
    irq_n_pin = 1'b1;
    step(5);
    check("R7", pin_level, 1'b0, "level low while port pin low");
    port_pins[0] = 1'b1;
    step(4);
    check("R7", pin_level, 1'b1, "level high when all high");
    check("R10", irq_req, 1'b0, "no request after release");
    port_pu_en = '0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_dedicated_edge();
    t_edge_only_hold();
    t_level();
    t_mask();
    t_port();
    t_ack_edge_same();
    t_service_pulse();
    t_wired_no_double();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule